// File: doc/BRIEF.md
# Frame Buffer Write Watcher

This block sits beside the memory path and sees every processor store. When a store lands inside the part of main RAM that is currently being shown on screen, it sets a sticky `dirty` flag. A display fetch engine polls this flag to decide whether a new frame must be pulled. Once the engine has read a frame, it pulses `frameAck`, and that pulse clears the flag.

The visible window is defined by a 16-bit display base register, which is loaded one byte at a time. The window begins at the register value times four, measured as a byte offset into main RAM, and it covers a fixed length of 0x19000 bytes. The block drives the current start and exclusive end offsets on its outputs, so the fetch engine can use the same window. The RAM storage and the pixel scan-out are not part of this block.

Top module: `fbWatch`

## Requirements
- R1: After reset, `dirty` is 0, the base register is 0, `winStart` is 0x00000 and `winEnd` is 0x19000.
- R2: A base write with `baseWrSel`=0 loads register bits 15:8 from `baseWrData`, and one with `baseWrSel`=1 loads bits 7:0. In both cases the other byte keeps its value.
- R3: `winStart` equals the base register times four, which is the register shifted left by 2 bits. It shows the new value in the cycle after the base write.
- R4: `winEnd` equals `winStart` plus 0x19000, and it is exclusive: a store at offset `winEnd` is outside the window.
- R5: A store (`wrEn`=1) is a RAM store when its address lies in 0x700000..0x7FFFFF. Its offset is the address minus 0x700000. An aligned RAM store whose offset satisfies `winStart` <= offset < `winEnd` sets `dirty` in the next cycle. The size codes are `wrSize`=0 for a byte, 1 for a halfword and 2 for a word.
- R6: A store whose address is outside the RAM region, or whose offset is outside the window, leaves `dirty` unchanged.
- R7: A store is rejected and leaves `dirty` unchanged in three cases: a halfword with address bit 0 set, a word with address bits 1:0 not equal to 0, or any store with `wrSize`=3.
- R8: `dirty` stays at 1 until `frameAck` is seen. A `frameAck` without a set in the same cycle clears `dirty` in the next cycle.
- R9: If a window hit and `frameAck` occur in the same cycle, `dirty` is 1 afterwards.
- R10: A store made in the same cycle as a base write is compared against the old window. Stores from the next cycle onward are compared against the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor store strobe |
| wrAddr | input | 24 | Store byte address |
| wrSize | input | 2 | Store size: 0 byte, 1 halfword, 2 word, 3 invalid |
| baseWrEn | input | 1 | Base register byte write strobe |
| baseWrSel | input | 1 | 0 selects bits 15:8, 1 selects bits 7:0 |
| baseWrData | input | 8 | Byte value for the base register |
| frameAck | input | 1 | Display side has read a frame; clears the flag |
| dirty | output | 1 | Sticky flag: the visible window has been written |
| winStart | output | 20 | Window start, byte offset into RAM |
| winEnd | output | 20 | Window end (exclusive), byte offset into RAM |

## Verification
The assertions assume that all inputs are sampled clean at the rising edge. They also assume that `winStart` plus the window length never wraps past the 20-bit offset space, which holds for every 16-bit base value. The bench changes inputs only on falling edges and holds each strobe for exactly one cycle. It also uses base values whose windows stay inside the offset range, so the hit condition that the checker rebuilds from the ports always matches the requirement.

// File: rtl/fbWatch_pkg.sv
package fbWatch_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic ramWrite;  // aligned, legal store into the RAM region
    logic clearReq;  // display side finished a frame
    logic loadHi;    // load base bits [15:8]
    logic loadLo;    // load base bits [7:0]
  } ctlStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/fbWatch_ctrl.sv
module fbWatch_ctrl
  import fbWatch_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int OFF_W    = 20,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'h700000
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSize,
  input  logic              baseWrEn,
  input  logic              baseWrSel,
  input  logic              frameAck,
  output ctlStrobe_t        strobe
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] RAM_TAG = RAM_BASE[ADDR_W-1:OFF_W];

  logic inRam;
  logic aligned;

  assign inRam = (wrAddr[ADDR_W-1:OFF_W] == RAM_TAG);

  always_comb begin
    unique case (wrSize)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~wrAddr[0];
      SZ_WORD: aligned = (wrAddr[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  always_comb begin
    strobe.ramWrite = wrEn & inRam & aligned;
    strobe.clearReq = frameAck;
    strobe.loadHi   = baseWrEn & ~baseWrSel;
    strobe.loadLo   = baseWrEn & baseWrSel;
  end
endmodule

// File: rtl/fbWatch_dp.sv
module fbWatch_dp
  import fbWatch_pkg::*;
#(
  parameter int OFF_W   = 20,
  parameter int BASE_W  = 16,
  parameter int SHIFT   = 2,
  parameter int WIN_LEN = 'h19000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [OFF_W-1:0] wrOff,
  input  logic [7:0]       baseWrData,
  output logic             dirty,
  output logic [OFF_W-1:0] winStart,
  output logic [OFF_W-1:0] winEnd
);
  localparam int HALF_W = BASE_W / 2;

  logic [BASE_W-1:0] baseReg;
  logic              inWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
    end else begin
      if (strobe.loadHi) baseReg[BASE_W-1:HALF_W] <= baseWrData[HALF_W-1:0];
      if (strobe.loadLo) baseReg[HALF_W-1:0]      <= baseWrData[HALF_W-1:0];
    end
  end

  assign winStart = OFF_W'({baseReg, {SHIFT{1'b0}}});
  assign winEnd   = winStart + OFF_W'(WIN_LEN);
  assign inWin    = (wrOff >= winStart) && (wrOff < winEnd);

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)                        dirty <= 1'b0;
    else if (strobe.ramWrite && inWin) dirty <= 1'b1;
    else if (strobe.clearReq)          dirty <= 1'b0;
  end
endmodule

// File: rtl/fbWatch.sv
module fbWatch
  import fbWatch_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int OFF_W   = 20,
  parameter int BASE_W  = 16,
  parameter int SHIFT   = 2,
  parameter int WIN_LEN = 'h19000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'h700000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSize,
  input  logic              baseWrEn,
  input  logic              baseWrSel,
  input  logic [7:0]        baseWrData,
  input  logic              frameAck,
  output logic              dirty,
  output logic [OFF_W-1:0]  winStart,
  output logic [OFF_W-1:0]  winEnd
);
  ctlStrobe_t strobe;

  fbWatch_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RAM_BASE(RAM_BASE)) ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .baseWrEn(baseWrEn), .baseWrSel(baseWrSel), .frameAck(frameAck),
    .strobe(strobe)
  );

  fbWatch_dp #(.OFF_W(OFF_W), .BASE_W(BASE_W), .SHIFT(SHIFT), .WIN_LEN(WIN_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrOff(wrAddr[OFF_W-1:0]),
    .baseWrData(baseWrData), .dirty(dirty), .winStart(winStart), .winEnd(winEnd)
  );
endmodule

// File: rtl/fbWatch_chk.sv
module fbWatch_chk #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 20,
  parameter int BASE_W = 16,
  parameter int SHIFT  = 2,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'h700000
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        wrSize,
  input logic              baseWrEn,
  input logic              baseWrSel,
  input logic [7:0]        baseWrData,
  input logic              frameAck,
  input logic              dirty,
  input logic [OFF_W-1:0]  winStart,
  input logic [OFF_W-1:0]  winEnd
);
  logic okAlign, okRam, hit;
  assign okAlign = (wrSize == 2'd0) || (wrSize == 2'd1 && !wrAddr[0]) ||
                   (wrSize == 2'd2 && wrAddr[1:0] == 2'b00);
  assign okRam   = (wrAddr[ADDR_W-1:OFF_W] == RAM_BASE[ADDR_W-1:OFF_W]);
  assign hit     = wrEn && okAlign && okRam &&
                   (wrAddr[OFF_W-1:0] >= winStart) && (wrAddr[OFF_W-1:0] < winEnd);

  // R5, R9
  a_r5_hit_sets: assert property (@(posedge clk) disable iff (!rstN) hit |=> dirty);
  // R6, R7
  a_r7_no_false_set: assert property (@(posedge clk) disable iff (!rstN)
    (!dirty && !hit) |=> !dirty);
  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (dirty && !frameAck) |=> dirty);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (frameAck && !hit) |=> !dirty);
  // R2, R3
  a_r3_hi_load: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrEn && !baseWrSel) |=> winStart[BASE_W+SHIFT-1 -: 8] == $past(baseWrData));
endmodule

bind fbWatch fbWatch_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE_W(BASE_W),
                           .SHIFT(SHIFT), .RAM_BASE(RAM_BASE)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
  .baseWrEn(baseWrEn), .baseWrSel(baseWrSel), .baseWrData(baseWrData),
  .frameAck(frameAck), .dirty(dirty), .winStart(winStart), .winEnd(winEnd)
);

// File: tb/fbWatch_tb.sv
module fbWatch_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [23:0] wrAddr = '0;
  logic [1:0]  wrSize = '0;
  logic        baseWrEn = 1'b0;
  logic        baseWrSel = 1'b0;
  logic [7:0]  baseWrData = '0;
  logic        frameAck = 1'b0;
  logic        dirty;
  logic [19:0] winStart, winEnd;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fbWatch dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .baseWrEn(baseWrEn), .baseWrSel(baseWrSel), .baseWrData(baseWrData),
    .frameAck(frameAck), .dirty(dirty), .winStart(winStart), .winEnd(winEnd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then sample after the edge
  task automatic cyc(bit we, logic [23:0] a, logic [1:0] sz, bit be, bit bs,
                     logic [7:0] bd, bit ack);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrSize = sz;
    baseWrEn = be; baseWrSel = bs; baseWrData = bd; frameAck = ack;
    @(negedge clk);
    wrEn = 0; baseWrEn = 0; frameAck = 0;
  endtask

  task automatic st(logic [23:0] a, logic [1:0] sz);
    cyc(1, a, sz, 0, 0, 0, 0);
  endtask
  task automatic ack();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask
  task automatic setBase(logic [15:0] v);
    cyc(0, 0, 0, 1, 0, v[15:8], 0);
    cyc(0, 0, 0, 1, 1, v[7:0], 0);
  endtask

  task automatic tReset();
    chk("R1 dirty", dirty, 0);
    chk("R1 start", winStart, 20'h0);
    chk("R1 end", winEnd, 20'h19000);
  endtask

  task automatic tBase();
    setBase(16'h1234);
    chk("R3 start", winStart, 20'h048D0);
    chk("R4 end", winEnd, 20'h1D8D0);
    cyc(0, 0, 0, 1, 0, 8'h56, 0);
    chk("R2 hi only", winStart, 20'h158D0);
    cyc(0, 0, 0, 1, 1, 8'h01, 0);
    chk("R2 lo only", winStart, 20'h15804);
  endtask

  task automatic tWindow();
    setBase(16'h0100); ack();
    st(24'h700400, 0); chk("R5 byte at start", dirty, 1); ack();
    chk("R8 ack clears", dirty, 0);
    st(24'h7003FF, 0); chk("R6 below start", dirty, 0);
    st(24'h719400, 0); chk("R4 end exclusive", dirty, 0);
    st(24'h7193FF, 0); chk("R5 byte last", dirty, 1); ack();
    st(24'h7193FE, 1); chk("R5 half", dirty, 1); ack();
    st(24'h7193FC, 2); chk("R5 word", dirty, 1); ack();
  endtask

  task automatic tRegion();
    st(24'h600400, 0); chk("R6 below RAM", dirty, 0);
    st(24'h800400, 0); chk("R6 above RAM", dirty, 0);
  endtask

  task automatic tAlign();
    st(24'h700401, 1); chk("R7 half odd", dirty, 0);
    st(24'h700402, 2); chk("R7 word off2", dirty, 0);
    st(24'h700401, 2); chk("R7 word off1", dirty, 0);
    st(24'h700400, 3); chk("R7 size3", dirty, 0);
  endtask

  task automatic tSticky();
    st(24'h700800, 2);
    repeat (5) cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8 sticky", dirty, 1);
    st(24'h600000, 0);
    chk("R8 sticky other write", dirty, 1);
    ack(); chk("R8 cleared", dirty, 0);
  endtask

  task automatic tCollide();
    cyc(1, 24'h700500, 0, 0, 0, 0, 1);
    chk("R9 set wins", dirty, 1); ack();
  endtask

  task automatic tSwitch();
    // window 0x400.., base hi -> 0x10 gives base 0x1000, start 0x4000
    cyc(1, 24'h700400, 0, 1, 0, 8'h10, 0);
    chk("R10 old window used", dirty, 1);
    chk("R10 new start", winStart, 20'h04000);
    ack();
    st(24'h700400, 0); chk("R10 old start now out", dirty, 0);
    st(24'h704000, 0); chk("R10 new window hit", dirty, 1); ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBase();
    tWindow();
    tRegion();
    tAlign();
    tSticky();
    tCollide();
    tSwitch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule